// File: doc/BRIEF.md
# One-Shot Prescaled Down-Counter

This peripheral times a single interval. Software loads a 16-bit prescaler reload value and a 16-bit count value over a small 8-bit register bus. It then sets the run bit. While running, the prescaler divides the clock, and each prescaler wrap takes one step off the count. When the count has to step below zero, the block produces a one-cycle pulse, clears its own run bit so that it halts, latches a pending flag, and raises its interrupt line if interrupts are enabled.

The 16-bit values are written as two bytes, low byte first. The low byte waits in a staging byte. The whole value is committed on the high-byte write, so the counter never runs on a half-updated value. The bus read port is combinational on the address.

Top module: `oneshot_pulse_counter`

## Requirements
- R1: After reset, all registers read 0x00, and `uflow_o` and `irq_o` are low.
- R2: The register map is: address 0 is the prescaler low byte, 1 the prescaler high byte, 2 the count low byte, 3 the count high byte, and 4 the control byte. The control byte holds the run bit in bit 0, the interrupt enable in bit 1 and the pending flag in bit 2; its other bits read 0. All five addresses read back what the block holds.
- R3: A write to address 0 or 2 only stages its byte, and the register readback does not change. A write to address 1 or 3 commits {written byte, staged byte} to the prescaler or to the count, respectively.
- R4: With prescaler value P and count value C, `uflow_o` is high exactly (C+1)*(P+1) clock cycles after the clock edge that sets the run bit from stopped. The prescaler restarts from P on that start.
- R5: On underflow, `uflow_o` is high for exactly one cycle, the run bit reads 0, and the count reads 0xFFFF.
- R6: Underflow sets the pending flag. The flag stays set until a control write with bit 2 at 0. A control write with bit 2 at 1 leaves the flag unchanged. If an underflow and a clearing write fall on the same cycle, the underflow wins.
- R7: `irq_o` is high exactly when both the pending flag and the interrupt enable are set.
- R8: Writing 0 to the run bit stops counting. While stopped, the count holds its value and no underflow occurs.
- R9: Setting the run bit again after a stop resumes from the current count value: the next underflow comes (C'+1)*(P+1) cycles later, where C' is the count read while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| uflow_o | output | 1 | One-cycle pulse on underflow |
| irq_o | output | 1 | Interrupt request |

## Verification
The count-hold assertion takes for granted that software changes the count only through the address-3 commit. The single-pulse assertion takes for granted that no bus write loads a count and restarts the counter in the cycle just after an underflow. The stimulus always writes a full low/high pair before it starts the counter. Restarts come only through separate control writes, two or more cycles after the pulse. Random prescaler and count values are kept small so that every interval can be measured exactly against the (C+1)*(P+1) formula.

// File: rtl/oneshot_pulse_counter.sv
module oneshot_pulse_counter #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          uflow_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_PL = AW'(0);
  localparam logic [AW-1:0] A_PH = AW'(1);
  localparam logic [AW-1:0] A_CL = AW'(2);
  localparam logic [AW-1:0] A_CH = AW'(3);
  localparam logic [AW-1:0] A_CTL = AW'(4);

  logic [15:0] presc_q, pcnt_q, cnt_q;
  logic [7:0]  stage_q;
  logic        run_q, ien_q, pend_q, uflow_q;
  logic        tick, ufl_evt, wr_ctl;

  assign tick    = run_q && (pcnt_q == 16'd0);
  assign ufl_evt = tick && (cnt_q == 16'd0);
  assign wr_ctl  = bus_we && (bus_addr == A_CTL);
  assign uflow_o = uflow_q;
  assign irq_o   = pend_q & ien_q;

  always_comb begin
    case (bus_addr)
      A_PL:    bus_rdata = presc_q[7:0];
      A_PH:    bus_rdata = presc_q[15:8];
      A_CL:    bus_rdata = cnt_q[7:0];
      A_CH:    bus_rdata = cnt_q[15:8];
      A_CTL:   bus_rdata = {5'b0, pend_q, ien_q, run_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
      pcnt_q  <= '0;
      cnt_q   <= '0;
      stage_q <= '0;
      run_q   <= 1'b0;
      ien_q   <= 1'b0;
      pend_q  <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      uflow_q <= ufl_evt;
      if (run_q) begin
        if (tick) begin
          pcnt_q <= presc_q;
          cnt_q  <= cnt_q - 16'd1;
        end else begin
          pcnt_q <= pcnt_q - 16'd1;
        end
      end
      if (ufl_evt) begin
        run_q  <= 1'b0;
        pend_q <= 1'b1;
      end
      if (bus_we) begin
        case (bus_addr)
          A_PL, A_CL: stage_q <= bus_wdata;
          A_PH:       presc_q <= {bus_wdata, stage_q};
          A_CH:       cnt_q   <= {bus_wdata, stage_q};
          default:    ;
        endcase
      end
      if (wr_ctl) begin
        ien_q <= bus_wdata[1];
        run_q <= bus_wdata[0] & ~ufl_evt;
        if (bus_wdata[0] && !run_q) pcnt_q <= presc_q;
        if (!bus_wdata[2] && !ufl_evt) pend_q <= 1'b0;
      end
    end
  end

  AST_UFL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_o |-> (!run_q && pend_q)); // R5
  AST_UFL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_o |=> !uflow_o); // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(wr_ctl && !bus_wdata[2])) |=> pend_q); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(bus_we && bus_addr == A_CH)) |=> $stable(cnt_q)); // R8
  AST_UFL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_o && ien_q) |-> irq_o); // R7
endmodule

// File: tb/test_oneshot_pulse_counter.sv
module test_oneshot_pulse_counter;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] bus_addr = 0;
  logic       bus_we = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       uflow_o, irq_o;
  int checks = 0, errors = 0;

  oneshot_pulse_counter i_oneshot_pulse_counter (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uflow_o(uflow_o), .irq_o(irq_o));

  always #10 clk = ~clk;

  function automatic int exp_cycles(int p, int c);
    return (c + 1) * (p + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_addr = a[2:0]; bus_wdata = d[7:0]; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    bus_addr = a[2:0];
    #1 d = bus_rdata;
  endtask

  task automatic rd16(int a, output int v);
    int lo, hi;
    rd(a, lo); rd(a + 1, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic load(int p, int c);
    wr(0, p & 255); wr(1, p >> 8); wr(2, c & 255); wr(3, c >> 8);
  endtask

  task automatic wait_ufl(output int n);
    n = 0;
    while (!uflow_o && n < 100000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, n, p, c, ien, cr;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(a, v); chk("R1 reg", v, 0);
    end
    chk("R1 uflow", uflow_o, 0); chk("R1 irq", irq_o, 0);
    rst_n = 1;

    wr(0, 8'h34);
    rd16(0, v); chk("R3 staged only", v, 0);
    wr(1, 8'h12);
    rd16(0, v); chk("R2/R3 prescaler commit", v, 16'h1234);
    wr(2, 8'hCD);
    rd16(2, v); chk("R3 count staged only", v, 0);
    wr(3, 8'hAB);
    rd16(2, v); chk("R2/R3 count commit", v, 16'hABCD);
    wr(4, 8'h06);
    rd(4, v); chk("R6 write 1 keeps clear flag", v, 8'h02);
    rd(5, v); chk("R2 unused addr", v, 0);

    for (int it = 0; it < 20; it++) begin
      p = (it == 0) ? 0 : $urandom_range(0, 5);
      c = (it == 1) ? 0 : $urandom_range(0, 6);
      ien = $urandom_range(0, 1);
      load(p, c);
      wr(4, 1 | (ien << 1));
      wait_ufl(n);
      chk("R4 interval", n, exp_cycles(p, c));
      rd(4, v); chk("R5 run cleared / R6 pending", v, 8'h04 | (ien << 1));
      chk("R7 irq", irq_o, ien);
      chk("R5 single pulse", uflow_o, 0);
      rd16(2, v); chk("R5 wrap", v, 16'hFFFF);
      wr(4, 8'h04 | (ien << 1));
      rd(4, v); chk("R6 sticky", v[2], 1);
      wr(4, 0);
      rd(4, v); chk("R6 clear", v, 0);
      chk("R7 irq low", irq_o, 0);
    end

    load(3, 10);
    wr(4, 8'h03);
    repeat (9) @(negedge clk);
    wr(4, 8'h02);
    rd16(2, cr);
    checks++;
    if (cr >= 10) begin errors++; $display("FAIL R8: actual %0h expected below a", cr); end
    n = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (uflow_o) n++; end
    chk("R8 no underflow stopped", n, 0);
    rd16(2, v); chk("R8 count holds", v, cr);
    wr(4, 8'h03);
    wait_ufl(n);
    chk("R9 resume interval", n, exp_cycles(3, cr));
    chk("R7 irq after resume", irq_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule